// File: doc/BRIEF.md
# Two-Wire Bus Controller with Clock Stretching

This block is a single-controller engine for a two-wire serial bus (I2C). A local command port accepts one operation at a time: a START condition, a STOP condition, a byte write, or a byte read. Each operation is carried out on open-drain clock and data lines. The block never drives a line high. For each line it gives a pull-low enable, and it reads the resolved line level back.

Each bit period is built from four equal quarter-phases. A quarter lasts max(prescale, 1) system clocks, so the serial clock runs at the system clock divided by four times the prescaler. The prescaler is latched when a command is accepted.

When stretching is enabled, the engine freezes its phase timing for as long as a target holds the clock line low after the controller has released it. A level interrupt is asserted whenever the unit is enabled and idle. Arbitration, target mode and ten-bit addressing are not part of the block.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: After reset `busy`, `scl_oe` and `sda_oe` are 0. `irq` is 0 while `enable` is 0, and 1 while `enable` is 1 and no operation runs.
- R2: An accepted command raises `busy` on the next clock. With q = max(`prescale`,1) latched at acceptance, `busy` stays high for 4*q clocks for START and STOP, and for 36*q clocks for a byte, plus any stretch stall.
- R3: START (`cmd_op`=0) releases both lines, then pulls SDA low while SCL is released, then pulls SCL low. It is the only operation that pulls SDA low while SCL is released.
- R4: STOP (`cmd_op`=1) pulls SDA low with SCL low, releases SCL, and then releases SDA. It is the only operation that releases SDA while SCL is released.
- R5: A write (`cmd_op`=2) sends `cmd_data` MSB first and pulls SDA low for each 0 bit. On the ninth bit it releases SDA. `ack_seen` becomes 1 if SDA was low when sampled in that ninth bit, else 0.
- R6: A read (`cmd_op`=3) releases SDA for eight bits and samples each bit in the third quarter. At completion it presents the eight bits MSB first on `rx_data`. On the ninth bit it pulls SDA low if `cmd_ack`=1 and releases it if `cmd_ack`=0.
- R7: During a byte, SDA changes only while SCL is pulled low.
- R8: With `stretch_en`=1, phase timing halts while SCL is released by the controller but reads low. With `stretch_en`=0, a low SCL has no effect on timing.
- R9: A `cmd_valid` while `busy` is 1 is ignored and does not change the running operation.
- R10: `irq` drops on the clock after a command is accepted and returns when the operation completes.
- R11: Deasserting `enable` releases both lines at once and returns the engine to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Unit enable; low aborts and releases lines |
| stretch_en | input | 1 | Honour targets holding SCL low |
| prescale | input | PW | Clocks per quarter-phase (0 acts as 1) |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmd_data | input | DW | Byte to write |
| cmd_ack | input | 1 | For reads: 1 sends ACK (SDA low) |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| busy | output | 1 | Operation in progress |
| irq | output | 1 | Level interrupt: enabled and idle |
| rx_data | output | DW | Last byte read |
| ack_seen | output | 1 | Ack observed on last write |

## Verification
The properties assume that commands follow a legal bus order: START before bytes, and STOP only after a START or a byte. They also assume that `prescale` and `stretch_en` are held steady during an operation, and that `scl_i`/`sda_i` are the wired-AND of the block's enables and a target model. The bench issues only START, byte, STOP sequences. Its target changes SDA only after it sees SCL fall, and it stretches SCL only after a falling edge. Random prescaler values, data and ack choices stay within these rules.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  // Clocks per quarter-phase; a zero setting behaves like one.
  function automatic logic [31:0] quarter_len(input logic [31:0] p);
    return (p == 32'd0) ? 32'd1 : p;
  endfunction

  // Quarter-phases taken by one operation.
  function automatic int unsigned op_quarters(input logic is_byte, input int unsigned dw);
    return is_byte ? 4 * (dw + 1) : 4;
  endfunction
endpackage

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer
  import i2c_stretch_pkg::*;
#(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [PW-1:0] load_val,
  input  logic          run,
  input  logic          hold,
  output logic          tick
);
  logic [PW-1:0] div_q;
  logic [PW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == div_q - 1'b1);
  assign tick   = run && !hold && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= PW'(1);
      cnt_q <= '0;
    end else if (clear) begin
      div_q <= PW'(quarter_len(32'(load_val)));
      cnt_q <= '0;
    end else if (run && !hold) begin
      if (at_end) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_phase_seq.sv
module i2c_phase_seq
  import i2c_stretch_pkg::*;
#(
  parameter int unsigned DW  = 8,
  localparam int unsigned BCW = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           accept,
  input  op_e            op_in,
  input  logic           tick,
  output logic           busy,
  output logic [1:0]     phase,
  output logic [BCW-1:0] bitn,
  output op_e            op_q,
  output logic           sample_evt,
  output logic           bit_end_evt,
  output logic           done_evt
);
  logic is_byte;
  logic last_bit;

  assign is_byte     = op_q[1];
  assign last_bit    = !is_byte || (bitn == BCW'(DW));
  assign sample_evt  = busy && tick && (phase == 2'd2) && is_byte;
  assign bit_end_evt = busy && tick && (phase == 2'd3);
  assign done_evt    = bit_end_evt && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= 2'd0;
      bitn  <= '0;
      op_q  <= OP_START;
    end else if (!enable) begin
      busy  <= 1'b0;
      phase <= 2'd0;
      bitn  <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      op_q  <= op_in;
      phase <= 2'd0;
      bitn  <= '0;
    end else if (busy && tick) begin
      phase <= phase + 2'd1;
      if (phase == 2'd3) begin
        if (last_bit) busy <= 1'b0;
        else          bitn <= bitn + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_line_drive.sv
module i2c_line_drive
  import i2c_stretch_pkg::*;
#(
  parameter int unsigned DW  = 8,
  localparam int unsigned BCW = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           accept,
  input  logic [DW-1:0]  cmd_data,
  input  logic           cmd_ack,
  input  logic           busy,
  input  op_e            op_q,
  input  logic [1:0]     phase,
  input  logic [BCW-1:0] bitn,
  input  logic           sample_evt,
  input  logic           bit_end_evt,
  input  logic           done_evt,
  input  logic           sda_i,
  output logic           scl_oe,
  output logic           sda_oe,
  output logic [DW-1:0]  rx_data,
  output logic           ack_seen
);
  logic [DW-1:0] shift_q;
  logic          samp_q;
  logic          ackd_q;
  logic          hold_scl_q;
  logic          hold_sda_q;
  logic          ack_bit;
  logic          bit_pull;
  logic          scl_pull;
  logic          sda_pull;

  assign ack_bit = (bitn == BCW'(DW));

  // Pull-low request for SDA during the current byte bit.
  always_comb begin
    if (ack_bit)               bit_pull = (op_q == OP_READ) ? ackd_q : 1'b0;
    else if (op_q == OP_WRITE) bit_pull = !shift_q[DW-1];
    else                       bit_pull = 1'b0;
  end

  always_comb begin
    scl_pull = hold_scl_q;
    sda_pull = hold_sda_q;
    if (busy) begin
      unique case (op_q)
        OP_START: begin
          scl_pull = (phase == 2'd0) ? hold_scl_q : (phase == 2'd3);
          sda_pull = phase[1];
        end
        OP_STOP: begin
          scl_pull = (phase == 2'd0);
          sda_pull = (phase != 2'd3);
        end
        default: begin
          scl_pull = (phase == 2'd0) || (phase == 2'd3);
          sda_pull = bit_pull;
        end
      endcase
    end
  end

  assign scl_oe = enable && scl_pull;
  assign sda_oe = enable && sda_pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q    <= '0;
      samp_q     <= 1'b0;
      ackd_q     <= 1'b0;
      hold_scl_q <= 1'b0;
      hold_sda_q <= 1'b0;
      rx_data    <= '0;
      ack_seen   <= 1'b0;
    end else if (!enable) begin
      hold_scl_q <= 1'b0;
      hold_sda_q <= 1'b0;
    end else begin
      if (accept) begin
        shift_q <= cmd_data;
        ackd_q  <= cmd_ack;
      end
      if (sample_evt) begin
        samp_q <= sda_i;
        if (ack_bit && op_q == OP_WRITE) ack_seen <= !sda_i;
      end
      if (bit_end_evt && !ack_bit && op_q[1]) shift_q <= {shift_q[DW-2:0], samp_q};
      if (done_evt) begin
        unique case (op_q)
          OP_START: begin hold_scl_q <= 1'b1; hold_sda_q <= 1'b1; end
          OP_STOP:  begin hold_scl_q <= 1'b0; hold_sda_q <= 1'b0; end
          default:  begin hold_scl_q <= 1'b1; hold_sda_q <= 1'b0; end
        endcase
        if (op_q == OP_READ) rx_data <= shift_q;
      end
    end
  end
endmodule

// File: rtl/i2c_stretch_ctrl.sv
module i2c_stretch_ctrl
  import i2c_stretch_pkg::*;
#(
  parameter int unsigned PW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          stretch_en,
  input  logic [PW-1:0] prescale,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_ack,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          irq,
  output logic [DW-1:0] rx_data,
  output logic          ack_seen
);
  localparam int unsigned BCW = $clog2(DW + 1);

  logic           accept;
  logic           tick;
  logic           hold_stall;
  logic           sample_evt;
  logic           bit_end_evt;
  logic           done_evt;
  logic [1:0]     phase;
  logic [BCW-1:0] bitn;
  op_e            op_q;

  assign accept     = enable && cmd_valid && !busy;
  assign hold_stall = stretch_en && busy && !scl_oe && !scl_i;
  assign irq        = enable && !busy;

  i2c_quarter_timer #(.PW(PW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept || !enable),
    .load_val (prescale),
    .run      (busy),
    .hold     (hold_stall),
    .tick     (tick)
  );

  i2c_phase_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .accept      (accept),
    .op_in       (op_e'(cmd_op)),
    .tick        (tick),
    .busy        (busy),
    .phase       (phase),
    .bitn        (bitn),
    .op_q        (op_q),
    .sample_evt  (sample_evt),
    .bit_end_evt (bit_end_evt),
    .done_evt    (done_evt)
  );

  i2c_line_drive #(.DW(DW)) u_lines (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .accept      (accept),
    .cmd_data    (cmd_data),
    .cmd_ack     (cmd_ack),
    .busy        (busy),
    .op_q        (op_q),
    .phase       (phase),
    .bitn        (bitn),
    .sample_evt  (sample_evt),
    .bit_end_evt (bit_end_evt),
    .done_evt    (done_evt),
    .sda_i       (sda_i),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .rx_data     (rx_data),
    .ack_seen    (ack_seen)
  );
endmodule

// File: rtl/i2c_stretch_checker.sv
module i2c_stretch_checker
  import i2c_stretch_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       stretch_en,
  input logic       cmd_valid,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic       irq,
  input logic       accept,
  input logic       tick,
  input logic       done_evt,
  input logic [1:0] phase,
  input op_e        op_q
);
  logic [7:0] qcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            qcnt <= '0;
    else if (accept)       qcnt <= '0;
    else if (busy && tick) qcnt <= qcnt + 8'd1;
  end

  // R2: the operation ends on its last quarter-phase
  p_quarters_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (qcnt == 8'(op_quarters(op_q[1], DW) - 1)));

  // R3: SDA is pulled low with SCL released only by START
  p_start_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $rose(sda_oe) && !scl_oe) |-> (busy && op_q == OP_START));

  // R4: SDA is released with SCL released only by STOP
  p_stop_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $fell(sda_oe) && !scl_oe) |-> (busy && op_q == OP_STOP));

  // R7: SDA is stable while SCL is released inside a byte
  p_sda_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && busy && $past(busy) && op_q[1] && $past(op_q[1]) && (sda_oe != $past(sda_oe)))
      |-> (scl_oe && $past(scl_oe)));

  // R8: a held SCL freezes the phase
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && busy && stretch_en && !scl_oe && !scl_i) |=> (!enable || $stable(phase)));

  // R9: commands during busy leave the operation alone
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(op_q));

  // R10: the interrupt drops after acceptance
  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !irq);

  // R10: the interrupt returns after completion
  p_irq_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && enable) |=> (irq || !enable));

  // R11: disabling returns the engine to idle
  p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);
endmodule

bind i2c_stretch_ctrl i2c_stretch_checker #(.DW(DW)) u_chk (.*);

// File: tb/i2c_stretch_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_stretch_ctrl_bench;
  localparam int PW = 8;
  localparam int DW = 8;
  localparam int STR_N = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          stretch_en = 1'b0;
  logic [PW-1:0] prescale = '0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [DW-1:0] cmd_data = '0;
  logic          cmd_ack = 1'b0;
  logic          scl_oe, sda_oe, busy, irq, ack_seen;
  logic [DW-1:0] rx_data;
  logic          scl_line, sda_line;

  // target model state
  logic [8:0] tgt_bits = 9'h1FF;
  logic       tgt_hold = 1'b0;
  logic       arm = 1'b0;
  logic       fired = 1'b0;
  int         stretch_cnt = 0;
  int         tgt_idx = 9;
  logic       tgt_low;
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  logic [8:0] cap = '0;
  int         ncap = 0;
  int         start_cnt = 0, stop_cnt = 0;

  int n_chk = 0, n_fail = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  assign tgt_low  = (tgt_idx <= 8) && !tgt_bits[8 - tgt_idx];
  assign scl_line = !scl_oe && (stretch_cnt == 0) && !tgt_hold;
  assign sda_line = !sda_oe && !tgt_low;

  i2c_stretch_ctrl #(.PW(PW), .DW(DW)) u_i2c_stretch_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .stretch_en(stretch_en),
    .prescale(prescale), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ack(cmd_ack), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .irq(irq),
    .rx_data(rx_data), .ack_seen(ack_seen)
  );

  always @(posedge clk) begin
    if (stretch_cnt != 0) stretch_cnt <= stretch_cnt - 1;
    if (cmd_valid && !busy && enable) begin
      tgt_idx <= 0; ncap <= 0; cap <= '0; fired <= 1'b0;
    end else begin
      if (prev_scl && !scl_line) begin
        tgt_idx <= tgt_idx + 1;
        if (arm && !fired) begin stretch_cnt <= STR_N; fired <= 1'b1; end
      end
      if (!prev_scl && scl_line) begin cap <= {cap[7:0], sda_line}; ncap <= ncap + 1; end
    end
    if (prev_scl && scl_line && prev_sda && !sda_line) start_cnt <= start_cnt + 1;
    if (prev_scl && scl_line && !prev_sda && sda_line) stop_cnt <= stop_cnt + 1;
    prev_scl <= scl_line;
    prev_sda <= sda_line;
  end

  function automatic int exp_q(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int exp_len(input logic is_byte, input int p);
    return (is_byte ? 36 : 4) * exp_q(p);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input logic a,
                         output int len, output logic irq_after);
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_ack = a; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    irq_after = irq;
    len = 0;
    while (busy && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int len;
    logic ia;
    int s0, p0;
    logic [7:0] d;
    logic a;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe && !irq, "R1 reset state", {busy, scl_oe, sda_oe, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R1 irq idle", irq, 1);

    // START with prescale 3
    prescale = 8'd3;
    s0 = start_cnt;
    run_cmd(2'd0, 8'h00, 1'b0, len, ia);
    chk(len == exp_len(1'b0, 3), "R2 start length", len, exp_len(1'b0, 3));
    chk(start_cnt == s0 + 1, "R3 start seen", start_cnt - s0, 1);
    chk(ia == 1'b0, "R10 irq drop", ia, 0);
    chk(irq == 1'b1, "R10 irq back", irq, 1);

    // write 0xA5, target acks
    tgt_bits = 9'b1_1111_1110;
    s0 = start_cnt; p0 = stop_cnt;
    run_cmd(2'd2, 8'hA5, 1'b0, len, ia);
    chk(len == exp_len(1'b1, 3), "R2 byte length", len, exp_len(1'b1, 3));
    chk(cap[8:1] == 8'hA5 && ncap == 9, "R5 write bits", cap[8:1], 8'hA5);
    chk(ack_seen == 1'b1, "R5 ack seen", ack_seen, 1);
    chk(start_cnt == s0 && stop_cnt == p0, "R7 no edge in byte", start_cnt + stop_cnt - s0 - p0, 0);

    // write with no ack, prescale 0
    prescale = 8'd0;
    tgt_bits = 9'h1FF;
    run_cmd(2'd2, 8'h3C, 1'b0, len, ia);
    chk(len == exp_len(1'b1, 0), "R2 prescale zero", len, exp_len(1'b1, 0));
    chk(ack_seen == 1'b0, "R5 nack", ack_seen, 0);

    // read 0x6B, controller sends ACK
    tgt_bits = {8'h6B, 1'b1};
    run_cmd(2'd3, 8'h00, 1'b1, len, ia);
    chk(rx_data == 8'h6B, "R6 read data", rx_data, 8'h6B);
    chk(cap[0] == 1'b0, "R6 ack driven", cap[0], 0);

    // read with NACK
    tgt_bits = {8'h81, 1'b1};
    run_cmd(2'd3, 8'h00, 1'b0, len, ia);
    chk(rx_data == 8'h81, "R6 read data 2", rx_data, 8'h81);
    chk(cap[0] == 1'b1, "R6 nack released", cap[0], 1);

    // stretching enabled
    prescale = 8'd2;
    stretch_en = 1'b1;
    arm = 1'b1;
    tgt_bits = 9'h1FF;
    run_cmd(2'd2, 8'h96, 1'b0, len, ia);
    arm = 1'b0;
    chk(len > exp_len(1'b1, 2) && len <= exp_len(1'b1, 2) + STR_N, "R8 stall length", len, exp_len(1'b1, 2) + STR_N);
    chk(cap[8:1] == 8'h96, "R8 data through stretch", cap[8:1], 8'h96);

    // stretching disabled, target holds SCL
    stretch_en = 1'b0;
    tgt_hold = 1'b1;
    run_cmd(2'd2, 8'h55, 1'b0, len, ia);
    tgt_hold = 1'b0;
    chk(len == exp_len(1'b1, 2), "R8 hold ignored", len, exp_len(1'b1, 2));

    // STOP
    tgt_bits = 9'h1FF;
    p0 = stop_cnt;
    run_cmd(2'd1, 8'h00, 1'b0, len, ia);
    chk(len == exp_len(1'b0, 2), "R2 stop length", len, exp_len(1'b0, 2));
    chk(stop_cnt == p0 + 1, "R4 stop seen", stop_cnt - p0, 1);
    chk(!scl_oe && !sda_oe, "R4 lines released", {scl_oe, sda_oe}, 0);

    // command while busy is ignored
    prescale = 8'd4;
    p0 = stop_cnt;
    @(negedge clk);
    cmd_op = 2'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    len = 1;
    @(negedge clk); len++;
    cmd_op = 2'd1; cmd_valid = 1'b1;
    @(negedge clk); len++;
    cmd_valid = 1'b0;
    while (busy && len < 5000) begin len++; @(negedge clk); end
    len--;
    chk(len == exp_len(1'b0, 4), "R9 busy length", len, exp_len(1'b0, 4));
    chk(stop_cnt == p0, "R9 no stop", stop_cnt - p0, 0);

    // random byte traffic
    for (int i = 0; i < 10; i++) begin
      int p;
      p = int'($urandom_range(0, 4));
      prescale = 8'(p);
      d = 8'($urandom);
      a = 1'($urandom);
      tgt_bits = {8'hFF, !a};
      run_cmd(2'd2, d, 1'b0, len, ia);
      chk(len == exp_len(1'b1, p) && cap[8:1] == d, "R5 random write", cap[8:1], d);
      chk(ack_seen == a, "R5 random ack", ack_seen, a);
      d = 8'($urandom);
      a = 1'($urandom);
      tgt_bits = {d, 1'b1};
      run_cmd(2'd3, 8'h00, a, len, ia);
      chk(rx_data == d && cap[0] == !a, "R6 random read", rx_data, d);
    end

    // disable mid-transfer
    prescale = 8'd3;
    tgt_bits = 9'h1FF;
    @(negedge clk);
    cmd_op = 2'd2; cmd_data = 8'h00; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    enable = 1'b0;
    #0.5;
    chk(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
    @(negedge clk);
    chk(!busy && !irq, "R11 idle disabled", {busy, irq}, 0);
    enable = 1'b1;
    @(negedge clk);
    chk(irq && !scl_oe && !sda_oe, "R11 re-enable idle", {irq, scl_oe, sda_oe}, 4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule